// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column addresses for one SDRAM read or write burst. When a start pulse arrives, it captures the start column, the access direction and the current burst settings: the length code, the ordering bit and the single-write mode bit. It then emits one column address per clock. On the final beat of a fixed-length burst it raises a last-beat flag.

Each beat moves only the low bits of the column that lie inside the burst-aligned block. With sequential ordering those bits increment and wrap. With interleaved ordering they are the start bits XOR the beat index. A page-length burst walks the 256 columns of the page and wraps around. It does not end until it is stopped.

A memory controller drives the start and stop inputs from its command stream. A stop ends the burst at once. A new start at any time aborts the running burst and begins the new sequence on the very next beat. A reserved length code runs as a single beat and raises a configuration error flag.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, `col_valid`, `last_beat` and `cfg_err` are all 0.
- R2: A `start` sampled at a clock edge makes `col_valid` 1 from that edge onward. The first beat shows `col_out` equal to the sampled `start_col`, and each following clock shows the next beat.
- R3: The length code `bl_code` selects the beat count: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. `last_beat` is 1 on the final beat only. `col_valid` is 0 on the clock after the final beat unless a new start was sampled.
- R4: When `burst_ilv` is 0 (sequential) and the length is L, beat k shows the start column with its low log2(L) bits replaced by (start + k) mod L. All higher bits are unchanged.
- R5: When `burst_ilv` is 1 (interleaved) and the length is L, beat k shows the start column with its low log2(L) bits replaced by (start XOR k) in those bits.
- R6: Code 3'b111 with `burst_ilv` 0 is a page burst. Column bits 7..0 count up from the start value modulo 256, bit 8 stays fixed, the burst continues without limit and `last_beat` is never 1.
- R7: When `wr_single` is 1 and `is_write` is 1 at start, the burst has exactly one beat, whatever the length code. Reads with `wr_single` 1 use the programmed length.
- R8: A `stop` sampled without `start` makes `col_valid` 0 from the next clock, at any length including page mode.
- R9: A `start` sampled during a running burst replaces it. The next clock shows beat 0 of the new burst. `start` takes priority over a `stop` sampled at the same edge.
- R10: A reserved code runs as a 1-beat burst with `cfg_err` 1 from the first beat until the next start. The reserved codes are 3'b100, 3'b101 and 3'b110, plus 3'b111 with `burst_ilv` 1. For valid codes `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new burst (aborts any running one) |
| is_write | input | 1 | 1 when the starting access is a write |
| start_col | input | COL_W | First column of the burst |
| bl_code | input | 3 | Burst length code |
| burst_ilv | input | 1 | 0 sequential, 1 interleaved ordering |
| wr_single | input | 1 | Force writes to one beat |
| stop | input | 1 | End the running burst |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is being presented |
| last_beat | output | 1 | Current beat is the last of a fixed-length burst |
| cfg_err | output | 1 | The current burst was started with a reserved code |

## Verification
The bench aims at the wrap points. These are sequential starts near the top of a 4- or 8-column block and a page burst starting at 0x1FD. A design that let the carry escape the block, or that touched bit 8, would show a wrong column at the wrap. Interleaved starts at odd offsets catch a design that adds instead of XORing. Writes in single-write mode, reads in the same mode, and reserved codes catch a wrong beat count, which shows up as a missing or extra beat. Back-to-back starts, a start together with a stop, and a stop in page mode catch a design that lets one more stale beat through or lets stop win over start.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
   localparam logic [2:0] LEN_ONE   = 3'b000;
   localparam logic [2:0] LEN_TWO   = 3'b001;
   localparam logic [2:0] LEN_FOUR  = 3'b010;
   localparam logic [2:0] LEN_EIGHT = 3'b011;
   localparam logic [2:0] LEN_PAGE  = 3'b111;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } order_e;
endpackage

// File: rtl/col_len_decode.sv
module col_len_decode
   import sdram_col_pkg::*;
#(
   parameter int PAGE_W = 8
) (
   input  logic [2:0]        code,
   input  order_e            order,
   input  logic              is_write,
   input  logic              wr_single,
   output logic [PAGE_W-1:0] mask,
   output logic              full,
   output logic              err
);
   initial begin
      if (PAGE_W < 3) $error("PAGE_W must cover an 8-beat block");
   end

   always_comb begin
      mask = '0;
      full = 1'b0;
      err  = 1'b0;
      unique case (code)
         LEN_ONE:   mask = '0;
         LEN_TWO:   mask = PAGE_W'(1);
         LEN_FOUR:  mask = PAGE_W'(3);
         LEN_EIGHT: mask = PAGE_W'(7);
         LEN_PAGE: begin
            if (order == ORD_SEQ) begin
               mask = '1;
               full = 1'b1;
            end else begin
               err = 1'b1;
            end
         end
         default:   err = 1'b1;
      endcase
      if (is_write && wr_single) begin
         mask = '0;
         full = 1'b0;
      end
   end
endmodule

// File: rtl/col_beat_ctr.sv
module col_beat_ctr #(
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic [PAGE_W-1:0] mask_in,
   input  logic              full_in,
   output logic              active,
   output logic [PAGE_W-1:0] cnt,
   output logic [PAGE_W-1:0] mask_q,
   output logic              last
);
   logic full_q;

   assign last = active && !full_q && (cnt == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         mask_q <= '0;
         full_q <= 1'b0;
      end else if (start) begin
         active <= 1'b1;
         cnt    <= '0;
         mask_q <= mask_in;
         full_q <= full_in;
      end else if (stop) begin
         active <= 1'b0;
      end else if (active) begin
         if (last) active <= 1'b0;
         cnt <= cnt + 1'b1;
      end
   end

   // R3
   beat_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !full_q) |-> (cnt <= mask_q));
endmodule

// File: rtl/col_addr_gen.sv
module col_addr_gen
   import sdram_col_pkg::*;
#(
   parameter int COL_W  = 9,
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [COL_W-1:0]  start_col,
   input  order_e            order,
   input  logic [PAGE_W-1:0] mask,
   input  logic [PAGE_W-1:0] cnt,
   output logic [COL_W-1:0]  col
);
   logic [COL_W-1:0]  base_q;
   order_e            ord_q;
   logic [PAGE_W-1:0] seq_low;
   logic [PAGE_W-1:0] ilv_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         ord_q  <= ORD_SEQ;
      end else if (load) begin
         base_q <= start_col;
         ord_q  <= order;
      end
   end

   assign seq_low = base_q[PAGE_W-1:0] + cnt;
   assign ilv_low = base_q[PAGE_W-1:0] ^ cnt;

   for (genvar i = 0; i < PAGE_W; i++) begin : g_low
      always_comb begin
         if (!mask[i])             col[i] = base_q[i];
         else if (ord_q == ORD_ILV) col[i] = ilv_low[i];
         else                      col[i] = seq_low[i];
      end
   end

   if (COL_W > PAGE_W) begin : g_high
      assign col[COL_W-1:PAGE_W] = base_q[COL_W-1:PAGE_W];
   end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
   import sdram_col_pkg::*;
#(
   parameter int COL_W     = 9,
   parameter int PAGE_COLS = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_write,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       bl_code,
   input  logic             burst_ilv,
   input  logic             wr_single,
   input  logic             stop,
   output logic [COL_W-1:0] col_out,
   output logic             col_valid,
   output logic             last_beat,
   output logic             cfg_err
);
   localparam int PAGE_W = $clog2(PAGE_COLS);

   initial begin
      if ((1 << PAGE_W) != PAGE_COLS) $error("PAGE_COLS must be a power of two");
      if (COL_W < PAGE_W) $error("COL_W must hold a page offset");
   end

   logic [PAGE_W-1:0] dec_mask;
   logic              dec_full;
   logic              dec_err;
   logic [PAGE_W-1:0] cnt;
   logic [PAGE_W-1:0] mask_q;
   logic              err_q;
   order_e            order;

   assign order = order_e'(burst_ilv);

   col_len_decode #(.PAGE_W(PAGE_W)) i_dec (
      .code(bl_code), .order(order), .is_write(is_write), .wr_single(wr_single),
      .mask(dec_mask), .full(dec_full), .err(dec_err)
   );

   col_beat_ctr #(.PAGE_W(PAGE_W)) i_ctr (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
      .mask_in(dec_mask), .full_in(dec_full),
      .active(col_valid), .cnt(cnt), .mask_q(mask_q), .last(last_beat)
   );

   col_addr_gen #(.COL_W(COL_W), .PAGE_W(PAGE_W)) i_addr (
      .clk(clk), .rst_n(rst_n), .load(start), .start_col(start_col),
      .order(order), .mask(mask_q), .cnt(cnt), .col(col_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     err_q <= 1'b0;
      else if (start) err_q <= dec_err;
   end
   assign cfg_err = err_q;

   // R2
   first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (col_valid && col_out == $past(start_col)));
   // R3
   end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat && !start) |=> !col_valid);
   // R8
   stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> !col_valid);
   // R3
   keeps_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && !last_beat && !stop && !start) |=> col_valid);
   // R10
   reserved_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (bl_code[2] && !(bl_code == 3'b111 && !burst_ilv))) |=> (cfg_err && last_beat));
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !col_valid |-> !last_beat);
endmodule

// File: tb/test_sdram_col_seq.sv
module test_sdram_col_seq;
   localparam int CLK_PERIOD = 10;
   localparam int COL_W = 9;

   typedef struct {
      logic [COL_W-1:0] col;
      logic             last;
      logic             err;
      string            req;
   } beat_t;

   logic clk = 0, rst_n = 0, start = 0, is_write = 0, burst_ilv = 0, wr_single = 0, stop = 0;
   logic [COL_W-1:0] start_col = '0;
   logic [2:0]       bl_code = '0;
   logic [COL_W-1:0] col_out;
   logic col_valid, last_beat, cfg_err;

   int checks = 0, errors = 0;
   beat_t exp_q[$];
   logic hold_stop = 0;
   logic done = 0;

   sdram_col_seq i_sdram_col_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
      .start_col(start_col), .bl_code(bl_code), .burst_ilv(burst_ilv),
      .wr_single(wr_single), .stop(stop), .col_out(col_out),
      .col_valid(col_valid), .last_beat(last_beat), .cfg_err(cfg_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // length from the requirement tables: 0 means page burst
   function automatic int exp_len(logic [2:0] c, logic ilv, logic wr, logic ws);
      int l;
      case (c)
         3'b000: l = 1;
         3'b001: l = 2;
         3'b010: l = 4;
         3'b011: l = 8;
         3'b111: l = ilv ? 1 : 0;
         default: l = 1;
      endcase
      if (wr && ws) l = 1;
      return l;
   endfunction

   function automatic logic exp_err(logic [2:0] c, logic ilv);
      return (c inside {3'b100, 3'b101, 3'b110}) || (c == 3'b111 && ilv);
   endfunction

   function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int l, logic ilv, int k);
      int span;
      int off;
      span = (l == 0) ? 256 : l;
      off  = ilv ? ((s % span) ^ k) : (((s % span) + k) % span);
      return COL_W'((s / span) * span + off);
   endfunction

   // tail: 0 natural end then idle, 1 stop, 2 chain, 3 chain with stop at the next start
   task automatic burst(input logic [COL_W-1:0] s, input logic [2:0] c, input logic ilv,
                        input logic wr, input logic ws, input int nshow, input int tail,
                        input string req);
      int l;
      int n;
      l = exp_len(c, ilv, wr, ws);
      n = (tail == 0) ? l : nshow;
      for (int k = 0; k < n; k++) begin
         beat_t b;
         b.col  = exp_col(s, l, ilv, k);
         b.last = (l != 0) && (k == l - 1);
         b.err  = exp_err(c, ilv);
         b.req  = req;
         exp_q.push_back(b);
      end
      start = 1; start_col = s; bl_code = c; burst_ilv = ilv; is_write = wr; wr_single = ws;
      stop = hold_stop;
      @(negedge clk);
      start = 0; stop = 0; hold_stop = 0;
      for (int k = 1; k < n; k++) @(negedge clk);
      if (tail == 0) begin
         @(negedge clk); @(negedge clk);
      end else if (tail == 1) begin
         stop = 1; @(negedge clk); stop = 0; @(negedge clk);
      end else if (tail == 3) begin
         hold_stop = 1;
      end
   endtask

   // monitor: pops expected beats and compares
   always @(negedge clk) begin
      if (rst_n && col_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3/R8: unexpected beat col=%0h expected none", col_out);
         end else begin
            beat_t b;
            b = exp_q.pop_front();
            if (col_out !== b.col || last_beat !== b.last || cfg_err !== b.err) begin
               errors++;
               $display("FAIL %s: col=%0h last=%0b err=%0b expected col=%0h last=%0b err=%0b",
                        b.req, col_out, last_beat, cfg_err, b.col, b.last, b.err);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (col_valid !== 0 || last_beat !== 0 || cfg_err !== 0) begin
         errors++;
         $display("FAIL R1: valid=%0b last=%0b err=%0b expected 0 0 0", col_valid, last_beat, cfg_err);
      end
      rst_n = 1;
      @(negedge clk);
      burst(9'h005, 3'b000, 0, 0, 0, 0, 0, "R2 R3 len1");
      burst(9'h00E, 3'b001, 0, 0, 0, 0, 0, "R3 R4 len2 seq");
      burst(9'h036, 3'b010, 0, 0, 0, 0, 0, "R4 len4 seq wrap");
      burst(9'h10D, 3'b011, 0, 0, 0, 0, 0, "R4 len8 seq wrap");
      burst(9'h013, 3'b010, 1, 0, 0, 0, 0, "R5 len4 ilv");
      burst(9'h0AD, 3'b011, 1, 0, 0, 0, 0, "R5 len8 ilv");
      burst(9'h1FD, 3'b111, 0, 0, 0, 260, 1, "R6 page wrap");
      burst(9'h042, 3'b011, 0, 1, 1, 0, 0, "R7 single write");
      burst(9'h042, 3'b011, 0, 0, 1, 0, 0, "R7 read keeps length");
      burst(9'h044, 3'b011, 0, 1, 0, 0, 0, "R7 write bursts when mode off");
      burst(9'h0F0, 3'b011, 0, 0, 0, 3, 1, "R8 stop len8");
      burst(9'h020, 3'b011, 0, 0, 0, 3, 2, "R9 abort");
      burst(9'h0C7, 3'b010, 1, 0, 0, 2, 3, "R9 abort ilv");
      burst(9'h101, 3'b001, 0, 0, 0, 0, 0, "R9 start beats stop");
      burst(9'h077, 3'b101, 0, 0, 0, 0, 0, "R10 reserved 101");
      burst(9'h078, 3'b111, 1, 0, 0, 0, 0, "R10 page with ilv");
      burst(9'h079, 3'b110, 0, 0, 0, 0, 0, "R10 reserved 110");
      burst(9'h07A, 3'b001, 1, 0, 0, 0, 0, "R10 flag clears");
      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R3: %0d beats missing, expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule